// File: doc/BRIEF.md
# Banked Data Address Mapper

This block sits between the data port of an 8-bit microcontroller core and the memories and registers behind it. It turns each 8-bit data address into one physical target. The low half of data space (0x00–0x7F) is a window into a banked RAM. A segment register held inside the block picks the bank. The high half (0x80–0xFF) always holds the same fixed set of register and peripheral windows, whatever the bank.

Stack traffic is flagged by the core with a qualifier input. It always lands in bank 0. In bank 0 the top sixteen bytes of the low half form a guard zone that reads as all-ones, so a stack that runs past its base fetches a trapping value. The block produces selects, write enables, a physical RAM address and the read data returned to the core. The peripheral registers themselves live elsewhere.

Top module: `dmem_bank_mapper`

## Requirements
- R1: For a non-stack access to 0x00–0x7F with a nonzero segment, `ram_sel` is 1 and `ram_addr` = {segment, addr[6:0]}. A read returns `ram_rdata` and a write raises `ram_we`.
- R2: For a non-stack access to 0x00–0x6F with segment 0, `ram_sel` is 1 and `ram_addr` = {0, addr[6:0]}.
- R3: In bank 0, addresses 0x70–0x7F are a guard zone. A read returns 0xFF, no select is raised, and a write changes nothing: `ram_we` stays 0.
- R4: An access with `stk_acc`=1 to 0x00–0x7F uses bank 0 whatever the segment holds, and this includes the guard zone of R3.
- R5: The target and read data of any access to 0x80–0xFF do not depend on the segment value.
- R6: 0xF0–0xFE raise `regf_sel` with `regf_idx` = addr[3:0]. A read returns `regf_rdata` and a write raises `regf_we`.
- R7: Address 0xFF is the segment register. It is 0 after reset and a read returns its value. A write loads `wdata` at the clock edge, so the next access already uses the new bank.
- R8: `per_sel` is one-hot: bit 0 for 0x90–0xBF, bit 1 for 0xC0–0xDF, bit 2 for 0xE9–0xEF. A read returns `per_rdata` and a write raises `per_we`.
- R9: 0x80–0x8F and 0xE0–0xE8 read as 0x00, raise no select, and ignore writes.
- R10: With neither `rd_en` nor `wr_en` high, no select or write enable is raised and `cpu_rdata` is 0.
- R11: At most one of `ram_sel`, `regf_sel` and the `per_sel` bits is high in any cycle, and no write enable is high unless `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Data address from the core |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| stk_acc | input | 1 | Access is a stack access |
| ram_rdata | input | 8 | Read data from banked RAM |
| regf_rdata | input | 8 | Read data from register file |
| per_rdata | input | 8 | Read data from peripheral registers |
| ram_sel | output | 1 | Banked RAM selected |
| ram_we | output | 1 | Banked RAM write enable |
| ram_addr | output | BANK_W+7 | Physical RAM address {bank, offset} |
| regf_sel | output | 1 | Register-file window selected |
| regf_we | output | 1 | Register-file write enable |
| regf_idx | output | 4 | Register index |
| per_sel | output | 3 | One-hot peripheral group select |
| per_we | output | 1 | Peripheral write enable |
| cpu_rdata | output | 8 | Read data to the core |

## Verification
The assertions check on every cycle that the selects are exclusive and gated by the strobes, that stack traffic reaches bank 0, and that the guard and empty ranges return 0xFF and 0x00. They also check that the segment register holds except when written. Only the bench scenarios can show that the full address map decodes correctly under two segment values, and that the physical RAM address carries the right bank. They also show that a segment write steers the access right after it, and that the reset value reads back as 0.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int LOW_W  = ADDR_W - 1;

  localparam logic [ADDR_W-1:0] GUARD_LO = 8'h70;
  localparam logic [ADDR_W-1:0] PERX_LO  = 8'h90;
  localparam logic [ADDR_W-1:0] PERX_HI  = 8'hBF;
  localparam logic [ADDR_W-1:0] PERIO_LO = 8'hC0;
  localparam logic [ADDR_W-1:0] PERIO_HI = 8'hDF;
  localparam logic [ADDR_W-1:0] CORE_LO  = 8'hE9;
  localparam logic [ADDR_W-1:0] CORE_HI  = 8'hEF;
  localparam logic [ADDR_W-1:0] REGF_LO  = 8'hF0;
  localparam logic [ADDR_W-1:0] SEG_ADDR = 8'hFF;

  typedef enum logic [3:0] {
    TGT_NONE,
    TGT_RAM,
    TGT_GUARD,
    TGT_VOID,
    TGT_PERX,
    TGT_PERIO,
    TGT_CORE,
    TGT_REGF,
    TGT_SEG
  } tgt_e;
endpackage

// File: rtl/dmap_rst_sync.sv
module dmap_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/dmap_decode.sv
module dmap_decode
  import dmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              acc,
  input  logic              bank_zero,
  output tgt_e              tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (acc) begin
      if (!addr[ADDR_W-1]) begin
        tgt = (bank_zero && (addr >= GUARD_LO)) ? TGT_GUARD : TGT_RAM;
      end else if ((addr >= PERX_LO) && (addr <= PERX_HI)) begin
        tgt = TGT_PERX;
      end else if ((addr >= PERIO_LO) && (addr <= PERIO_HI)) begin
        tgt = TGT_PERIO;
      end else if ((addr >= CORE_LO) && (addr <= CORE_HI)) begin
        tgt = TGT_CORE;
      end else if (addr == SEG_ADDR) begin
        tgt = TGT_SEG;
      end else if (addr >= REGF_LO) begin
        tgt = TGT_REGF;
      end else begin
        tgt = TGT_VOID;
      end
    end
  end
endmodule

// File: rtl/dmap_seg_reg.sv
module dmap_seg_reg
  import dmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] seg_q
);
  logic [DATA_W-1:0] seg_d;

  always_comb begin
    seg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  seg_q <= '0;
    else if (we) seg_q <= seg_d;
  end

  assert_seg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(seg_q));
  assert_seg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (seg_q == $past(wdata)));
endmodule

// File: rtl/dmap_rdmux.sv
module dmap_rdmux
  import dmap_pkg::*;
(
  input  tgt_e              tgt,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] regf_rdata,
  input  logic [DATA_W-1:0] per_rdata,
  input  logic [DATA_W-1:0] seg_q,
  output logic [DATA_W-1:0] cpu_rdata
);
  always_comb begin
    cpu_rdata = '0;
    if (rd_en) begin
      unique case (tgt)
        TGT_RAM:   cpu_rdata = ram_rdata;
        TGT_GUARD: cpu_rdata = '1;
        TGT_PERX,
        TGT_PERIO,
        TGT_CORE:  cpu_rdata = per_rdata;
        TGT_REGF:  cpu_rdata = regf_rdata;
        TGT_SEG:   cpu_rdata = seg_q;
        default:   cpu_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dmem_bank_mapper.sv
module dmem_bank_mapper
  import dmap_pkg::*;
#(
  parameter int BANK_W = 8,
  localparam int PA_W = BANK_W + LOW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stk_acc,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] regf_rdata,
  input  logic [DATA_W-1:0] per_rdata,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [PA_W-1:0]   ram_addr,
  output logic              regf_sel,
  output logic              regf_we,
  output logic [3:0]        regf_idx,
  output logic [2:0]        per_sel,
  output logic              per_we,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              rst_n_int;
  logic [DATA_W-1:0] seg_q;
  logic [BANK_W-1:0] eff_bank;
  logic              bank_zero;
  logic              seg_we;
  tgt_e              tgt;

  dmap_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign eff_bank  = stk_acc ? '0 : seg_q[BANK_W-1:0];
  assign bank_zero = (eff_bank == '0);

  dmap_decode u_dec (
    .addr      (addr),
    .acc       (rd_en | wr_en),
    .bank_zero (bank_zero),
    .tgt       (tgt)
  );

  assign seg_we = (tgt == TGT_SEG) && wr_en;

  dmap_seg_reg u_seg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (seg_we),
    .wdata (wdata),
    .seg_q (seg_q)
  );

  dmap_rdmux u_mux (
    .tgt        (tgt),
    .rd_en      (rd_en),
    .ram_rdata  (ram_rdata),
    .regf_rdata (regf_rdata),
    .per_rdata  (per_rdata),
    .seg_q      (seg_q),
    .cpu_rdata  (cpu_rdata)
  );

  always_comb begin
    ram_sel  = (tgt == TGT_RAM);
    ram_we   = ram_sel && wr_en;
    ram_addr = {eff_bank, addr[LOW_W-1:0]};
    regf_sel = (tgt == TGT_REGF);
    regf_we  = regf_sel && wr_en;
    regf_idx = addr[3:0];
    per_sel  = {tgt == TGT_CORE, tgt == TGT_PERIO, tgt == TGT_PERX};
    per_we   = (|per_sel) && wr_en;
  end

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({ram_sel, regf_sel, per_sel}));
  assert_we_needs_wr_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ram_we || regf_we || per_we) |-> wr_en);
  assert_stack_bank0_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ram_sel && stk_acc) |-> (ram_addr[PA_W-1:LOW_W] == '0));
  assert_guard_reads_ff_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && !addr[7] && (addr[6:4] == 3'b111) && (stk_acc || (seg_q[BANK_W-1:0] == '0)))
      |-> ((cpu_rdata == 8'hFF) && !ram_sel && !ram_we));
  assert_void_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_en && ((addr[7:4] == 4'h8) || ((addr >= 8'hE0) && (addr <= 8'hE8))))
      |-> ((cpu_rdata == '0) && !ram_sel && !regf_sel && (per_sel == '0)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!rd_en && !wr_en) |-> (!ram_sel && !regf_sel && (per_sel == '0) && (cpu_rdata == '0)));
endmodule

// File: tb/dmem_bank_mapper_tb.sv
module dmem_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        stk_acc = 1'b0;
  logic [7:0]  ram_rdata = 8'h00;
  logic [7:0]  regf_rdata = 8'h00;
  logic [7:0]  per_rdata = 8'h00;
  logic        ram_sel, ram_we, regf_sel, regf_we, per_we;
  logic [14:0] ram_addr;
  logic [3:0]  regf_idx;
  logic [2:0]  per_sel;
  logic [7:0]  cpu_rdata;

  int checks = 0;
  int fails = 0;
  int ms = 0;

  always #4 clk = ~clk;

  dmem_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .stk_acc(stk_acc), .ram_rdata(ram_rdata),
    .regf_rdata(regf_rdata), .per_rdata(per_rdata), .ram_sel(ram_sel),
    .ram_we(ram_we), .ram_addr(ram_addr), .regf_sel(regf_sel),
    .regf_we(regf_we), .regf_idx(regf_idx), .per_sel(per_sel),
    .per_we(per_we), .cpu_rdata(cpu_rdata)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    checks++;
    fails++;
    finish_run();
  end

  function automatic string tag_for(int a, bit stk);
    if (a < 128) begin
      if (stk) return "R4";
      if (ms != 0) return "R1";
      return (a >= 'h70) ? "R3" : "R2";
    end
    if (a == 'hFF) return "R7";
    if (a >= 'hF0) return "R6";
    if ((a >= 'h90 && a <= 'hDF) || (a >= 'hE9 && a <= 'hEF)) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic acc(int a, bit rd, bit wr, bit stk, int wd, string req);
    int e_rsel, e_rwe, e_raddr, e_fsel, e_fwe, e_psel, e_pwe, e_rd, bank;
    @(negedge clk);
    addr = a[7:0]; rd_en = rd; wr_en = wr; stk_acc = stk; wdata = wd[7:0];
    ram_rdata = 8'($urandom); regf_rdata = 8'($urandom); per_rdata = 8'($urandom);
    #2;
    e_rsel = 0; e_rwe = 0; e_raddr = 0; e_fsel = 0; e_fwe = 0; e_psel = 0; e_pwe = 0; e_rd = 0;
    bank = stk ? 0 : ms;
    if (rd || wr) begin
      if (a < 128) begin
        if (bank == 0 && a >= 'h70) e_rd = 'hFF;
        else begin
          e_rsel = 1; e_rwe = wr; e_raddr = bank * 128 + a; e_rd = ram_rdata;
        end
      end else if (a >= 'h90 && a <= 'hBF) begin e_psel = 1; e_pwe = wr; e_rd = per_rdata; end
      else if (a >= 'hC0 && a <= 'hDF) begin e_psel = 2; e_pwe = wr; e_rd = per_rdata; end
      else if (a >= 'hE9 && a <= 'hEF) begin e_psel = 4; e_pwe = wr; e_rd = per_rdata; end
      else if (a == 'hFF) e_rd = ms;
      else if (a >= 'hF0) begin e_fsel = 1; e_fwe = wr; e_rd = regf_rdata; end
    end
    if (!rd) e_rd = 0;
    chk(req, "ram_sel", int'(ram_sel), e_rsel);
    chk(req, "ram_we", int'(ram_we), e_rwe);
    if (e_rsel != 0) chk(req, "ram_addr", int'(ram_addr), e_raddr);
    chk(req, "regf_sel", int'(regf_sel), e_fsel);
    chk(req, "regf_we", int'(regf_we), e_fwe);
    if (e_fsel != 0) chk(req, "regf_idx", int'(regf_idx), a % 16);
    chk(req, "per_sel", int'(per_sel), e_psel);
    chk(req, "per_we", int'(per_we), e_pwe);
    chk(req, "cpu_rdata", int'(cpu_rdata), e_rd);
    @(posedge clk);
    #1;
    if (wr && a == 'hFF) ms = wd & 'hFF;
  endtask

  initial begin
    // R10: idle during reset, nothing selected
    #3;
    chk("R10", "ram_sel in reset", int'(ram_sel), 0);
    chk("R10", "cpu_rdata in reset", int'(cpu_rdata), 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    acc('hFF, 1, 0, 0, 0, "R7");
    acc('h10, 0, 0, 0, 0, "R10");
    acc('h10, 0, 0, 1, 0, "R10");

    // R2 / R3 with segment 0
    acc('h00, 1, 0, 0, 0, "R2");
    acc('h6F, 0, 1, 0, 'h3C, "R2");
    acc('h70, 1, 0, 0, 0, "R3");
    acc('h7F, 1, 0, 0, 0, "R3");
    acc('h72, 0, 1, 0, 'h11, "R3");

    // R7 write then next access uses new bank
    acc('hFF, 0, 1, 0, 'h05, "R7");
    acc('hFF, 1, 0, 0, 0, "R7");
    acc('h20, 1, 0, 0, 0, "R7");
    acc('h7F, 0, 1, 0, 'h99, "R1");
    acc('h75, 1, 0, 0, 0, "R1");

    // R4 stack goes to bank 0, guard included
    acc('h10, 1, 0, 1, 0, "R4");
    acc('h6F, 0, 1, 1, 'h44, "R4");
    acc('h75, 1, 0, 1, 0, "R4");
    acc('h7E, 0, 1, 1, 'h44, "R4");

    // R6, R8, R9, R11 points
    acc('hF0, 1, 0, 0, 0, "R6");
    acc('hFD, 0, 1, 0, 'h2A, "R6");
    acc('h90, 1, 0, 0, 0, "R8");
    acc('hD3, 0, 1, 0, 'h01, "R8");
    acc('hEF, 1, 0, 0, 0, "R8");
    acc('h8F, 1, 0, 0, 0, "R9");
    acc('hE5, 0, 1, 0, 'h77, "R9");
    acc('hE8, 1, 0, 1, 0, "R11");

    // R5: whole map read under two segment values
    for (int pass = 0; pass < 2; pass++) begin
      acc('hFF, 0, 1, 0, (pass == 0) ? 'h00 : 'hA5, "R7");
      for (int a = 0; a < 256; a++) begin
        acc(a, 1, 0, 0, 0, (a >= 128 && a != 'hFF) ? "R5" : tag_for(a, 1'b0));
      end
      for (int a = 0; a < 128; a++) begin
        acc(a, 1, 0, 1, 0, "R4");
      end
    end

    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    finish_run();
  end
endmodule